// File: doc/BRIEF.md
# Jump-Threshold Sample Corrector

This block sits after a digital low-pass filter that is allowed to make occasional large errors, for example because its supply runs below the level its slowest paths need. Each valid output sample from the filter is compared with the raw sample that came just before it. If the two differ by at least a threshold, the new sample is taken to be wrong: it is flagged and the earlier sample is sent out in its place. If they differ by less, the new sample goes out unchanged.

The threshold is a runtime input. It is set from the spread of the filter's error-free first difference, which is worked out elsewhere. The method works best when the passband is narrow, because consecutive correct samples then sit close together. The corrector itself runs on a safe supply and adds one register stage.

Top module: `diff_err_corrector`

## Requirements
- R1: While reset is active, and on the first clock after it ends, `out_valid` and `out_err` are 0.
- R2: The first valid sample after reset has no predecessor. It is output unchanged with `out_err` = 0, whatever the threshold is, and it only loads the history.
- R3: `out_valid` is exactly `in_valid` delayed by one clock. `out_err` is aligned with that output sample.
- R4: For every later valid sample, `out_err` = 1 if and only if |in_sample − previous raw sample| ≥ `thresh`. Equality counts as an error. The difference is signed and can be negative.
- R5: When a sample is flagged, `out_sample` equals the previous raw input sample.
- R6: When a sample is not flagged, `out_sample` equals the current input sample.
- R7: The history always takes the raw input sample, even when that sample was flagged and replaced. The next difference is therefore taken against the flagged value.
- R8: `out_err` is never 1 unless `out_valid` is 1.
- R9: A threshold of 0 flags every valid sample except the first one after reset.
- R10: The difference is formed one bit wider than the samples, so full-scale swings do not wrap. Going from +32767 to −32768 gives a magnitude of 65535. With `thresh` = 65535 that swing is flagged, while a swing of 32817 is not.
- R11: Cycles with `in_valid` = 0 leave the history unchanged, whatever is on `in_sample`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new filter sample is present |
| in_sample | input | DW (16) | Filter output sample, two's complement |
| thresh | input | DW (16) | Unsigned jump threshold, sampled with each valid input |
| out_valid | output | 1 | Corrected sample is present |
| out_sample | output | DW (16) | Corrected sample, two's complement |
| out_err | output | 1 | The sample was judged wrong and replaced |

## Verification
The assertions check the one-cycle valid pipeline and the rule that the flag appears only with valid on every cycle. They also check that a flagged sample becomes the held sample, that an unflagged one passes through, that the first sample is never flagged, and that idle cycles do not change the history. Only the bench scenarios can show the numeric outcomes. These include the equality case at the threshold, negative jumps, comparison against a replaced sample's raw value, threshold zero, and the widened difference at full-scale swings.

// File: rtl/ecor_pkg.sv
package ecor_pkg;
  typedef enum logic {
    HIST_EMPTY  = 1'b0,
    HIST_PRIMED = 1'b1
  } hist_state_e;
endpackage

// File: rtl/ecor_diff.sv
module ecor_diff #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] cur,
  input  logic signed [DW-1:0] prev,
  output logic        [DW-1:0] mag
);
  localparam int XW = DW + 1;

  function automatic logic [DW-1:0] abs_sat(input logic signed [XW-1:0] d);
    logic [XW-1:0] u;
    if (d[XW-1]) u = XW'(-d);
    else         u = XW'(d);
    if (u[XW-1]) return {DW{1'b1}};
    return u[DW-1:0];
  endfunction

  logic signed [XW-1:0] diff_w;
  assign diff_w = {cur[DW-1], cur} - {prev[DW-1], prev};
  assign mag    = abs_sat(diff_w);
endmodule

// File: rtl/ecor_history.sv
module ecor_history
  import ecor_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [DW-1:0] sample_in,
  output logic signed [DW-1:0] prev_q,
  output logic                 primed
);
  hist_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= HIST_EMPTY;
      prev_q <= '0;
    end else if (load) begin
      st_q   <= HIST_PRIMED;
      prev_q <= sample_in;
    end
  end

  assign primed = (st_q == HIST_PRIMED);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(prev_q));
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (prev_q == $past(sample_in)) && primed);
endmodule

// File: rtl/ecor_decide.sv
module ecor_decide #(
  parameter int DW = 16
) (
  input  logic                 primed,
  input  logic        [DW-1:0] mag,
  input  logic        [DW-1:0] thresh,
  input  logic signed [DW-1:0] cur,
  input  logic signed [DW-1:0] prev,
  output logic                 hit,
  output logic signed [DW-1:0] pick
);
  always_comb begin
    hit  = primed && (mag >= thresh);
    pick = hit ? prev : cur;
  end
endmodule

// File: rtl/diff_err_corrector.sv
module diff_err_corrector #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic        [DW-1:0] thresh,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample,
  output logic                 out_err
);
  logic signed [DW-1:0] prev_q;
  logic                 primed;
  logic        [DW-1:0] jump_mag;
  logic                 hit;
  logic signed [DW-1:0] pick;

  ecor_history #(.DW(DW)) u_hist (
    .clk(clk), .rst_n(rst_n), .load(in_valid),
    .sample_in(in_sample), .prev_q(prev_q), .primed(primed)
  );

  ecor_diff #(.DW(DW)) u_diff (
    .cur(in_sample), .prev(prev_q), .mag(jump_mag)
  );

  ecor_decide #(.DW(DW)) u_dec (
    .primed(primed), .mag(jump_mag), .thresh(thresh),
    .cur(in_sample), .prev(prev_q), .hit(hit), .pick(pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid && hit;
      if (in_valid) out_sample <= pick;
    end
  end

  p_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  p_flag_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);
  p_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !primed) |=> !out_err && out_sample == $past(in_sample));
  p_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit) |=> out_err && out_sample == $past(prev_q));
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hit) |=> !out_err && out_sample == $past(in_sample));
endmodule

// File: tb/diff_err_corrector_test.sv
module diff_err_corrector_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NV = 12;
  localparam int VW = 1 + DW + DW + 1 + 1 + DW;

  // {in_valid, in_sample, thresh, exp_valid, exp_err, exp_sample}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 16'sd10,     16'd100,   1'b1, 1'b0, 16'sd10},     // R2 first
    {1'b1, 16'sd50,     16'd100,   1'b1, 1'b0, 16'sd50},     // R6
    {1'b1, 16'sd150,    16'd100,   1'b1, 1'b1, 16'sd50},     // R4 equality, R5
    {1'b1, 16'sd160,    16'd100,   1'b1, 1'b0, 16'sd160},    // R7 vs raw 150
    {1'b0, 16'sd9999,   16'd0,     1'b0, 1'b0, 16'sd160},    // R3 idle
    {1'b1, 16'sd100,    16'd100,   1'b1, 1'b0, 16'sd100},    // R11 prev 160
    {1'b1, -16'sd1,     16'd100,   1'b1, 1'b1, 16'sd100},    // R4 negative
    {1'b1, -16'sd50,    16'd50,    1'b1, 1'b0, -16'sd50},    // R6 just below
    {1'b1, -16'sd50,    16'd0,     1'b1, 1'b1, -16'sd50},    // R9 zero
    {1'b1, 16'sd32767,  16'd65535, 1'b1, 1'b0, 16'sd32767},  // R10 below
    {1'b1, -16'sd32768, 16'd65535, 1'b1, 1'b1, 16'sd32767},  // R10 full swing
    {1'b1, 16'sd0,      16'd65535, 1'b1, 1'b0, 16'sd0}       // R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic [DW-1:0] thresh = '0;
  logic out_valid;
  logic signed [DW-1:0] out_sample;
  logic out_err;
  int n_run = 0;
  int n_fail = 0;

  diff_err_corrector #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .thresh(thresh), .out_valid(out_valid), .out_sample(out_sample),
    .out_err(out_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [DW+1:0] act, input logic [DW+1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic signed [DW-1:0] s, input logic [DW-1:0] t);
    @(negedge clk);
    in_valid = v; in_sample = s; thresh = t;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", {17'd0, out_valid}, '0);
    check("R1 err in reset", {17'd0, out_err}, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", {16'd0, out_valid, out_err}, '0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      step(e[VW-1], e[VW-2 -: DW], e[VW-2-DW -: DW]);
      check("R3 valid", {17'd0, out_valid}, {17'd0, e[DW+1]});
      check("R4 err", {17'd0, out_err}, {17'd0, e[DW]});
      if (e[DW+1]) check("R5/R6 sample", {2'b0, out_sample}, {2'b0, e[DW-1:0]});
    end

    // Mid-run reset, then a big jump with threshold 0: first sample passes (R2)
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1;
    check("R1 mid reset", {16'd0, out_valid, out_err}, '0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, -16'sd30000, 16'd0);
    check("R2 first unflagged", {1'b0, out_err, out_sample}, {1'b0, 1'b0, -16'sd30000});
    step(1'b1, -16'sd30000, 16'd0);
    check("R9 zero flags repeat", {1'b0, out_err, out_sample}, {1'b0, 1'b1, -16'sd30000});
    step(1'b0, 16'sd0, 16'd0);
    check("R8 no err without valid", {16'd0, out_valid, out_err}, '0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule